// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a register slave on a two-wire serial bus (I2C-compatible framing). It samples the clock and data lines on the system clock, recognises start and stop conditions, and answers a 7-bit device address formed from a fixed 6-bit prefix and one bit taken from a strap pin. After a matching write address, the first byte sets an internal register pointer and the following bytes are stored into the register file at that pointer. After a matching read address, the slave shifts out register contents starting at the current pointer.

Bit 7 of the pointer byte is an increment flag and the low bits select the register. With the flag set, the pointer advances after every byte transferred in either direction, so one transaction can fill or dump a run of registers. The data line is never driven high: the block outputs only an open-drain pull-down enable. A sticky mode input permanently silences the port once another control mode has been chosen.

Top module: `twi_regslave`

## Requirements
- R1: After reset the pull-down enable is low and every register reads 0x00.
- R2: An address byte whose upper six bits equal the prefix (default 001000) and whose seventh bit equals `strap_i` is acknowledged by pulling SDA low through the ninth clock; bit 0 of the address byte selects a read when 1 and a write when 0.
- R3: An address that does not match is not acknowledged, and every byte after it is ignored (no acknowledge, no register change) until the next start.
- R4: In a write, the byte after the address is the pointer byte (bit 7 = increment flag, bits [AW-1:0] = register index, other bits ignored); it is acknowledged, and each following byte is acknowledged and stored in the register the pointer selects.
- R5: With the increment flag at 1, the pointer advances by one after each written byte, wrapping from the last register to register 0.
- R6: With the increment flag at 0, successive written bytes all land in the same register.
- R7: A read returns, straight after the address acknowledge, the register at the pointer left by the previous transaction, most significant bit first.
- R8: In a burst read the pointer advances after each byte when the increment flag is 1 and stays put when it is 0.
- R9: When the master does not acknowledge a read byte, the slave stops sending and leaves SDA released until the next start.
- R10: The pull-down enable is asserted only while SCL is low, and an acknowledge is held for the whole high phase of the ninth clock.
- R11: A start in the middle of a byte abandons the transfer and restarts address reception; a stop returns the slave to idle.
- R12: Once `spi_mode_i` has been high for one clock, the port never drives SDA and never changes a register until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 1 | Strap level for address bit 0 of the 7-bit address |
| spi_mode_i | input | 1 | Alternate control mode selected; latched, disables the port |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| regs_o | output | 8*NREGS | Register file contents, register k in bits [8k+7:8k] |

## Verification
The bench writes bursts that run past the last register, so a pointer that fails to wrap would corrupt the wrong register or drop a byte. It issues a repeated start after four bits of a data byte; a slave that kept its bit count would misframe the new address and never acknowledge it. After a master NACK the bench keeps clocking and expects an all-ones byte, which catches a slave that keeps shifting data out. Mismatched addresses, both a wrong strap bit and a wrong prefix, are followed by pointer and data bytes that must leave the registers untouched, exposing a slave that only gates the first acknowledge.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int BYTE_BITS = 8;

    localparam logic [5:0] DEF_ADDR_HI = 6'b001000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } twi_st_e;

endpackage

// File: rtl/twi_linesync.sv
module twi_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);

    logic [STAGES-1:0] scl_ff_q;
    logic [STAGES-1:0] sda_ff_q;
    logic              scl_p_q;
    logic              sda_p_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff_q[g] <= 1'b1;
                    sda_ff_q[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_ff_q[g] <= scl_i;
                    sda_ff_q[g] <= sda_i;
                end else begin
                    scl_ff_q[g] <= scl_ff_q[(g == 0) ? 0 : g-1];
                    sda_ff_q[g] <= sda_ff_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_ff_q[STAGES-1];
            sda_p_q <= sda_ff_q[STAGES-1];
        end
    end

    assign scl_s    = scl_ff_q[STAGES-1];
    assign sda_s    = sda_ff_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_p_q;
    assign scl_fall = ~scl_s & scl_p_q;
    // data edges count as bus conditions only while the clock stays high
    assign ev_start = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign ev_stop  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
    parameter int NREGS = 8,
    parameter int AW    = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [AW-1:0]      rd_idx,
    output logic [7:0]         rd_data,
    output logic [8*NREGS-1:0] regs_flat
);

    genvar k;
    generate
        for (k = 0; k < NREGS; k++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_flat[8*k +: 8] <= 8'h00;
                end else if (wr_en && (wr_idx == AW'(k))) begin
                    regs_flat[8*k +: 8] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_data = regs_flat[8*rd_idx +: 8];

endmodule

// File: rtl/twi_regslave.sv
module twi_regslave
    import twi_pkg::*;
#(
    parameter int         NREGS       = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_HI     = DEF_ADDR_HI
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               strap_i,
    input  logic               spi_mode_i,
    output logic               sda_oe_o,
    output logic [8*NREGS-1:0] regs_o
);

    localparam int CW = $clog2(BYTE_BITS + 1);
    localparam int AW = $clog2(NREGS);
    localparam logic [CW-1:0] FULL_CNT = CW'(BYTE_BITS);

    typedef struct packed {
        twi_st_e       st;
        twi_st_e       ack_nx;
        logic [CW-1:0] cnt;
        logic [7:0]    sh;
        logic [AW-1:0] ptr;
        logic          incr;
        logic          oe;
        logic          lock;
        logic          mack;
    } slv_t;

    slv_t q, n;

    logic          scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
    logic          wr_en;
    logic [AW-1:0] wr_idx;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;
    logic          bus_idle;

    twi_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    twi_regfile #(.NREGS(NREGS), .AW(AW)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (q.ptr),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

    function automatic logic [AW-1:0] step_ptr(logic [AW-1:0] p, logic inc);
        return p + AW'(inc);
    endfunction

    always_comb begin
        n       = q;
        wr_en   = 1'b0;
        wr_idx  = q.ptr;
        wr_data = q.sh;
        n.lock  = q.lock | spi_mode_i;

        if (n.lock) begin
            n.st = ST_IDLE;
            n.oe = 1'b0;
        end else if (ev_start) begin
            n.st  = ST_ADDR;
            n.cnt = '0;
            n.oe  = 1'b0;
        end else if (ev_stop) begin
            n.st = ST_IDLE;
            n.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        n.sh  = {q.sh[6:0], sda_s};
                        n.cnt = q.cnt + CW'(1);
                    end else if (scl_fall && (q.cnt == FULL_CNT)) begin
                        n.cnt    = '0;
                        n.st     = ST_ACK;
                        n.oe     = 1'b1;
                        n.ack_nx = ST_WDATA;
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == {ADDR_HI, strap_i}) begin
                                n.ack_nx = q.sh[0] ? ST_RDATA : ST_PTR;
                            end else begin
                                n.st = ST_IDLE;
                                n.oe = 1'b0;
                            end
                        end else if (q.st == ST_PTR) begin
                            n.ptr  = q.sh[AW-1:0];
                            n.incr = q.sh[7];
                        end else begin
                            wr_en = 1'b1;
                            n.ptr = step_ptr(q.ptr, q.incr);
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        n.oe  = 1'b0;
                        n.cnt = '0;
                        n.st  = q.ack_nx;
                        if (q.ack_nx == ST_RDATA) begin
                            n.sh  = rd_data;
                            n.oe  = ~rd_data[7];
                            n.ptr = step_ptr(q.ptr, q.incr);
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        n.cnt = q.cnt + CW'(1);
                    end else if (scl_fall) begin
                        if (q.cnt == FULL_CNT) begin
                            n.oe  = 1'b0;
                            n.cnt = '0;
                            n.st  = ST_RACK;
                        end else begin
                            n.sh = {q.sh[6:0], 1'b0};
                            n.oe = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        n.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            n.st  = ST_RDATA;
                            n.sh  = rd_data;
                            n.oe  = ~rd_data[7];
                            n.ptr = step_ptr(q.ptr, q.incr);
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    n.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ack_nx: ST_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o = q.oe;
    assign bus_idle = (q.st == ST_IDLE);

endmodule

// File: rtl/twi_regslave_chk.sv
module twi_regslave_chk #(
    parameter int NREGS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_i,
    input logic               spi_mode_i,
    input logic               sda_oe_o,
    input logic               bus_idle,
    input logic [8*NREGS-1:0] regs_o
);

    // R10: pull-down only starts during the low phase of SCL
    a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R4: register stores happen only while SCL is low
    a_r4_store_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> !scl_i);

    // R12: once the alternate mode was seen, the line is released
    a_r12_lock_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_mode_i) |-> !sda_oe_o);

    // R3 / R9: an idle slave never pulls the line
    a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> !sda_oe_o);

endmodule

bind twi_regslave twi_regslave_chk #(.NREGS(NREGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .spi_mode_i (spi_mode_i),
    .sda_oe_o   (sda_oe_o),
    .bus_idle   (bus_idle),
    .regs_o     (regs_o)
);

// File: tb/twi_regslave_tb.sv
module twi_regslave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NREGS      = 8;
    localparam int H          = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic strap = 1'b0;
    logic spi = 1'b0;
    logic oe;
    logic [8*NREGS-1:0] regs;
    logic sda_line;

    assign sda_line = ~(m_low | oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_regslave #(.NREGS(NREGS)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .spi_mode_i (spi),
        .sda_oe_o   (oe),
        .regs_o     (regs)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] exp_r [NREGS];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic wt(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < NREGS; i++) begin
            chk(regs[8*i +: 8] == exp_r[i], req, $sformatf("reg%0d", i),
                int'(regs[8*i +: 8]), int'(exp_r[i]));
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; scl = 1'b1; wt(H);
        m_low = 1'b1; wt(H);
        scl = 1'b0; wt(H);
    endtask

    task automatic bus_rstart();
        m_low = 1'b0; wt(H);
        scl = 1'b1; wt(H);
        m_low = 1'b1; wt(H);
        scl = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wt(H);
        scl = 1'b1; wt(H);
        m_low = 1'b0; wt(2*H);
    endtask

    task automatic put_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            m_low = ~b[i]; wt(H);
            scl = 1'b1; wt(H);
            scl = 1'b0;
        end
    endtask

    // ack is 1 only if the line is low both early and late in the ninth high phase
    task automatic put_byte(input logic [7:0] b, output bit ack);
        logic early, late;
        put_bits(b, 8);
        m_low = 1'b0; wt(H);
        scl = 1'b1; wt(1);
        early = sda_line; wt(H - 2);
        late = sda_line; wt(1);
        scl = 1'b0;
        ack = !early && !late;
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wt(H);
            scl = 1'b1; wt(H/2);
            b[i] = sda_line; wt(H/2);
            scl = 1'b0;
        end
        m_low = mack; wt(H);
        scl = 1'b1; wt(H);
        scl = 1'b0;
        m_low = 1'b0;
    endtask

    task automatic t_reset();
        chk(oe == 1'b0, "R1", "oe after reset", int'(oe), 0);
        chk(regs == '0, "R1", "regs after reset", int'(regs[31:0]), 0);
    endtask

    task automatic t_write_single();
        bit a;
        bus_start();
        put_byte(8'h20, a);
        chk(a, "R2", "write address ack", int'(a), 1);
        chk(a, "R10", "ack held over ninth high phase", int'(a), 1);
        put_byte(8'h02, a);
        chk(a, "R4", "pointer byte ack", int'(a), 1);
        put_byte(8'hA5, a);
        chk(a, "R4", "data byte ack", int'(a), 1);
        bus_stop();
        exp_r[2] = 8'hA5;
        chk_regs("R4");
    endtask

    task automatic t_burst_incr();
        bit a;
        bus_start();
        put_byte(8'h20, a);
        put_byte(8'h86, a);
        put_byte(8'h11, a);
        put_byte(8'h22, a);
        put_byte(8'h33, a);
        chk(a, "R5", "last burst byte ack", int'(a), 1);
        bus_stop();
        exp_r[6] = 8'h11; exp_r[7] = 8'h22; exp_r[0] = 8'h33;
        chk_regs("R5");
    endtask

    task automatic t_burst_noincr();
        bit a;
        bus_start();
        put_byte(8'h20, a);
        put_byte(8'h04, a);
        put_byte(8'h44, a);
        put_byte(8'h55, a);
        put_byte(8'h66, a);
        bus_stop();
        exp_r[4] = 8'h66;
        chk_regs("R6");
    endtask

    task automatic t_read_current();
        bit a;
        logic [7:0] d;
        bus_start();
        put_byte(8'h21, a);
        chk(a, "R2", "read address ack", int'(a), 1);
        get_byte(1'b0, d);
        chk(d == 8'h66, "R7", "read at retained pointer", int'(d), 'h66);
        bus_stop();
    endtask

    task automatic t_burst_read();
        bit a;
        logic [7:0] d;
        bus_start();
        put_byte(8'h20, a);
        put_byte(8'h86, a);
        bus_rstart();
        put_byte(8'h21, a);
        get_byte(1'b1, d);
        chk(d == 8'h11, "R8", "incr read byte 0", int'(d), 'h11);
        get_byte(1'b1, d);
        chk(d == 8'h22, "R8", "incr read byte 1", int'(d), 'h22);
        get_byte(1'b0, d);
        chk(d == 8'h33, "R8", "incr read wraps", int'(d), 'h33);
        bus_rstart();
        put_byte(8'h20, a);
        put_byte(8'h02, a);
        bus_rstart();
        put_byte(8'h21, a);
        get_byte(1'b1, d);
        chk(d == 8'hA5, "R8", "fixed read byte 0", int'(d), 'hA5);
        get_byte(1'b0, d);
        chk(d == 8'hA5, "R8", "fixed read repeats", int'(d), 'hA5);
        bus_stop();
    endtask

    task automatic t_nack_release();
        bit a;
        logic [7:0] d;
        bus_start();
        put_byte(8'h21, a);
        get_byte(1'b0, d);
        chk(d == 8'hA5, "R9", "byte before nack", int'(d), 'hA5);
        get_byte(1'b0, d);
        chk(d == 8'hFF, "R9", "line released after nack", int'(d), 'hFF);
        chk(oe == 1'b0, "R9", "oe after nack", int'(oe), 0);
        bus_stop();
    endtask

    task automatic t_bad_addr();
        bit a;
        bus_start();
        put_byte(8'h22, a);
        chk(!a, "R3", "strap mismatch nack", int'(a), 0);
        put_byte(8'h01, a);
        chk(!a, "R3", "pointer ignored", int'(a), 0);
        put_byte(8'h77, a);
        chk(!a, "R3", "data ignored", int'(a), 0);
        bus_stop();
        bus_start();
        put_byte(8'h60, a);
        chk(!a, "R3", "prefix mismatch nack", int'(a), 0);
        put_byte(8'h03, a);
        put_byte(8'h99, a);
        bus_stop();
        chk_regs("R3");
    endtask

    task automatic t_restart();
        bit a;
        bus_start();
        put_byte(8'h20, a);
        put_byte(8'h01, a);
        put_bits(8'hF0, 4);
        bus_rstart();
        put_byte(8'h20, a);
        chk(a, "R11", "address after mid-byte restart", int'(a), 1);
        put_byte(8'h03, a);
        put_byte(8'h5A, a);
        bus_stop();
        exp_r[3] = 8'h5A;
        chk_regs("R11");
        chk(oe == 1'b0, "R11", "idle after stop", int'(oe), 0);
    endtask

    task automatic t_strap();
        bit a;
        strap = 1'b1; wt(H);
        bus_start();
        put_byte(8'h20, a);
        chk(!a, "R2", "old strap address refused", int'(a), 0);
        bus_stop();
        bus_start();
        put_byte(8'h22, a);
        chk(a, "R2", "strap-one address ack", int'(a), 1);
        put_byte(8'h05, a);
        put_byte(8'h9C, a);
        bus_stop();
        exp_r[5] = 8'h9C;
        chk_regs("R2");
        strap = 1'b0; wt(H);
    endtask

    task automatic t_spi_lock();
        bit a;
        spi = 1'b1; wt(1);
        spi = 1'b0; wt(H);
        bus_start();
        put_byte(8'h20, a);
        chk(!a, "R12", "locked port nack", int'(a), 0);
        put_byte(8'h00, a);
        put_byte(8'hEE, a);
        bus_stop();
        chk_regs("R12");
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) exp_r[i] = 8'h00;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_write_single();
        t_burst_incr();
        t_burst_noincr();
        t_read_current();
        t_burst_read();
        t_nack_release();
        t_bad_addr();
        t_restart();
        t_strap();
        t_spi_lock();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule